// File: doc/BRIEF.md
# Lookup-Table Two-Pass ALU

This block is an arithmetic/logic unit whose behaviour is set entirely by the contents of a writable lookup memory, with no adder or logic gates doing the arithmetic. A word operation is split into two byte-sized passes through the table. The low bytes go first with an external carry-in. Then both possible high-byte results, one for carry-in 0 and one for carry-in 1, are looked up together, and the carry produced by the low pass picks one of them. This is the carry-select scheme.

A host loads the table through a write port while the unit is idle. A requester presents an operation code, two operands and a carry-in, and pulses start. Two cycles later a one-cycle valid pulse marks a new word in the result holding register, along with zero, carry and negative flags that stay put until the next completion. The byte width is a parameter. The default of 4 keeps the default table small (2048 entries, 8-bit words). A width of 8 gives the 16-bit configuration.

Top module: `alu_lut_top`

## Requirements
- R1: A host write with `tbl_we_i` high while idle stores `tbl_data_i` = {carry_out, result_byte} at `tbl_addr_i` = {op, carry_in, a_byte, b_byte} (op in the top bits, b_byte in the bottom bits). Later operations use the new entry.
- R2: The low pass looks up {op, cin_i, a_lo, b_lo}. The high pass looks up {op, 0, a_hi, b_hi} and {op, 1, a_hi, b_hi}. The low entry's carry_out selects the second of these when it is 1 and the first when it is 0. The result word is {selected result_byte, low result_byte}.
- R3: `valid_o` is a one-cycle pulse in the second cycle after the clock edge that accepts a start. `busy_o` is high from that edge until the pulse.
- R4: `result_o` changes only in a cycle where `valid_o` is high, and holds its value in between.
- R5: `zero_o` is 1 exactly when the completed result word is all zeros.
- R6: `carry_o` equals the carry_out bit of the selected high-pass entry.
- R7: `neg_o` equals the most significant bit of the completed result.
- R8: The three flags change only in cycles where `valid_o` is high.
- R9: A table write presented while an operation is in progress is dropped, and the table is left unchanged.
- R10: A start presented together with a table write in idle is deferred. The write happens first, and the operation begins one cycle later using the operands captured with the request. Its valid pulse therefore arrives one cycle later than usual.
- R11: A start presented while busy is ignored. It produces no extra valid pulse and does not change the result.
- R12: After reset, `valid_o`, `busy_o`, `result_o` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we_i | input | 1 | Table write request |
| tbl_addr_i | input | OP_W+1+2*BYTE_W | Table write address {op, cin, a, b} |
| tbl_data_i | input | BYTE_W+1 | Table entry {carry_out, result_byte} |
| start_i | input | 1 | Start an operation |
| op_i | input | OP_W | Operation code |
| a_i | input | 2*BYTE_W | Operand A |
| b_i | input | 2*BYTE_W | Operand B |
| cin_i | input | 1 | Carry into the low pass |
| busy_o | output | 1 | Operation pending or in progress |
| valid_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2*BYTE_W | Result holding register |
| zero_o | output | 1 | Result is zero |
| carry_o | output | 1 | Final carry-out |
| neg_o | output | 1 | Result sign bit |

## Verification
The assertions assume a requester that offers start only while `busy_o` is low, or at least tolerates it being dropped. They also assume the table has been fully loaded before any operation, so that the lookups never return unknown entries. The stimulus loads every table entry before the first start. Starts and writes that land while the unit is busy are applied only in directed cases, where the bench checks that they are ignored. The vector loop waits for each valid pulse and for the following idle cycle before it launches the next operation.

// File: rtl/alu_lut_pkg.sv
package alu_lut_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } alu_st_e;
endpackage

// File: rtl/alu_lut_bank.sv
// Lookup memory: one copy per read port, all copies share the single write port,
// so each copy maps onto a simple dual-port block RAM.
module alu_lut_bank #(
  parameter int ADDR_W = 11,
  parameter int ENT_W  = 5,
  parameter int PORTS  = 2
) (
  input  logic                             clk,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                waddr_i,
  input  logic [ENT_W-1:0]                 wdata_i,
  input  logic [PORTS-1:0][ADDR_W-1:0]     raddr_i,
  output logic [PORTS-1:0][ENT_W-1:0]      rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar p = 0; p < PORTS; p++) begin : g_copy
    logic [ENT_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we_i) mem[waddr_i] <= wdata_i;
      rdata_o[p] <= mem[raddr_i[p]];
    end
  end
endmodule

// File: rtl/alu_lut_ctrl.sv
// Sequencer: accepts starts, defers a start that collides with a table write,
// forms the lookup addresses for the low and high passes, keeps the low result.
module alu_lut_ctrl
  import alu_lut_pkg::*;
#(
  parameter int BYTE_W = 4,
  parameter int OP_W   = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tbl_we_i,
  input  logic                         start_i,
  input  logic [OP_W-1:0]              op_i,
  input  logic [2*BYTE_W-1:0]          a_i,
  input  logic [2*BYTE_W-1:0]          b_i,
  input  logic                         cin_i,
  input  logic [BYTE_W:0]              lo_ent_i,
  output logic                         mem_we_o,
  output logic [1:0][OP_W+2*BYTE_W:0]  raddr_o,
  output logic [BYTE_W-1:0]            lo_res_o,
  output logic                         lo_c_o,
  output logic                         fin_o,
  output logic                         busy_o
);
  localparam int WORD_W = 2 * BYTE_W;

  alu_st_e st;
  logic pend;
  logic [OP_W-1:0]   p_op, op_q;
  logic [WORD_W-1:0] p_a, p_b;
  logic              p_cin;
  logic [BYTE_W-1:0] ahi_q, bhi_q;

  logic              idle, launch;
  logic [OP_W-1:0]   l_op;
  logic [WORD_W-1:0] l_a, l_b;
  logic              l_cin;

  always_comb begin
    idle     = (st == ST_IDLE);
    mem_we_o = tbl_we_i && idle;
    launch   = idle && !tbl_we_i && (pend || start_i);
    l_op     = pend ? p_op  : op_i;
    l_a      = pend ? p_a   : a_i;
    l_b      = pend ? p_b   : b_i;
    l_cin    = pend ? p_cin : cin_i;
    if (st == ST_LO)
      raddr_o[0] = {op_q, 1'b0, ahi_q, bhi_q};
    else
      raddr_o[0] = {l_op, l_cin, l_a[BYTE_W-1:0], l_b[BYTE_W-1:0]};
    raddr_o[1] = {op_q, 1'b1, ahi_q, bhi_q};
    fin_o      = (st == ST_HI);
    busy_o     = !idle || pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      pend     <= 1'b0;
      p_op     <= '0;
      p_a      <= '0;
      p_b      <= '0;
      p_cin    <= 1'b0;
      op_q     <= '0;
      ahi_q    <= '0;
      bhi_q    <= '0;
      lo_res_o <= '0;
      lo_c_o   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (tbl_we_i && start_i && !pend) begin
            pend  <= 1'b1;
            p_op  <= op_i;
            p_a   <= a_i;
            p_b   <= b_i;
            p_cin <= cin_i;
          end
          if (launch) begin
            st    <= ST_LO;
            pend  <= 1'b0;
            op_q  <= l_op;
            ahi_q <= l_a[WORD_W-1:BYTE_W];
            bhi_q <= l_b[WORD_W-1:BYTE_W];
          end
        end
        ST_LO: begin
          lo_res_o <= lo_ent_i[BYTE_W-1:0];
          lo_c_o   <= lo_ent_i[BYTE_W];
          st       <= ST_HI;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Two passes: low pass is always followed by the high pass, then idle.
  assert_low_then_high_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LO) |=> (st == ST_HI));
  assert_high_then_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HI) |=> (st == ST_IDLE));
  // A start seen while an operation runs never creates a deferred request.
  assert_no_pend_when_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |=> !$rose(pend));
  // A deferred request persists until it launches.
  assert_pend_launches_R10: assert property (@(posedge clk) disable iff (rst)
    pend |=> (pend || st == ST_LO));
endmodule

// File: rtl/alu_lut_out.sv
// Carry-select of the high entry, result holding register and flag logic.
module alu_lut_out #(
  parameter int BYTE_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fin_i,
  input  logic [BYTE_W-1:0]     lo_res_i,
  input  logic                  lo_c_i,
  input  logic [BYTE_W:0]       hi0_ent_i,
  input  logic [BYTE_W:0]       hi1_ent_i,
  output logic                  valid_o,
  output logic [2*BYTE_W-1:0]   result_o,
  output logic                  zero_o,
  output logic                  carry_o,
  output logic                  neg_o
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [BYTE_W:0]   sel;
  logic [WORD_W-1:0] word;

  always_comb begin
    sel  = lo_c_i ? hi1_ent_i : hi0_ent_i;
    word = {sel[BYTE_W-1:0], lo_res_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      zero_o   <= 1'b0;
      carry_o  <= 1'b0;
      neg_o    <= 1'b0;
    end else begin
      valid_o <= fin_i;
      if (fin_i) begin
        result_o <= word;
        zero_o   <= (word == '0);
        carry_o  <= sel[BYTE_W];
        neg_o    <= word[WORD_W-1];
      end
    end
  end

  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  assert_result_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(result_o) |-> valid_o);
  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable({zero_o, carry_o, neg_o}) |-> valid_o);
  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (zero_o == (result_o == '0)));
  assert_neg_flag_R7: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (neg_o == result_o[WORD_W-1]));
endmodule

// File: rtl/alu_lut_top.sv
module alu_lut_top #(
  parameter int BYTE_W = 4,
  parameter int OP_W   = 2,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int ADDR_W = OP_W + 1 + 2 * BYTE_W,
  localparam int ENT_W  = BYTE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_we_i,
  input  logic [ADDR_W-1:0] tbl_addr_i,
  input  logic [ENT_W-1:0]  tbl_data_i,
  input  logic              start_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              cin_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic [WORD_W-1:0] result_o,
  output logic              zero_o,
  output logic              carry_o,
  output logic              neg_o
);
  logic                        mem_we;
  logic [1:0][ADDR_W-1:0]      raddr;
  logic [1:0][ENT_W-1:0]       rdata;
  logic [BYTE_W-1:0]           lo_res;
  logic                        lo_c;
  logic                        fin;

  alu_lut_ctrl #(.BYTE_W(BYTE_W), .OP_W(OP_W)) u_ctrl (
    .clk(clk), .rst(rst), .tbl_we_i(tbl_we_i), .start_i(start_i),
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
    .lo_ent_i(rdata[0]), .mem_we_o(mem_we), .raddr_o(raddr),
    .lo_res_o(lo_res), .lo_c_o(lo_c), .fin_o(fin), .busy_o(busy_o)
  );

  alu_lut_bank #(.ADDR_W(ADDR_W), .ENT_W(ENT_W), .PORTS(2)) u_bank (
    .clk(clk), .we_i(mem_we), .waddr_i(tbl_addr_i), .wdata_i(tbl_data_i),
    .raddr_i(raddr), .rdata_o(rdata)
  );

  alu_lut_out #(.BYTE_W(BYTE_W)) u_out (
    .clk(clk), .rst(rst), .fin_i(fin), .lo_res_i(lo_res), .lo_c_i(lo_c),
    .hi0_ent_i(rdata[0]), .hi1_ent_i(rdata[1]), .valid_o(valid_o),
    .result_o(result_o), .zero_o(zero_o), .carry_o(carry_o), .neg_o(neg_o)
  );

  // Completion is always preceded by a busy cycle.
  assert_valid_after_busy_R3: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(busy_o));
endmodule

// File: tb/tb_alu_lut_top.sv
module tb_alu_lut_top;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 4;
  localparam int WW = 8;
  localparam int AW = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tbl_we = 1'b0;
  logic [AW-1:0] tbl_addr = '0;
  logic [BW:0] tbl_data = '0;
  logic start = 1'b0;
  logic [1:0] op = '0;
  logic [WW-1:0] a = '0, b = '0;
  logic cin = 1'b0;
  logic busy, valid, zero, carry, neg;
  logic [WW-1:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_lut_top #(.BYTE_W(BW), .OP_W(2)) dut (
    .clk(clk), .rst(rst), .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr),
    .tbl_data_i(tbl_data), .start_i(start), .op_i(op), .a_i(a), .b_i(b),
    .cin_i(cin), .busy_o(busy), .valid_o(valid), .result_o(result),
    .zero_o(zero), .carry_o(carry), .neg_o(neg)
  );

  // op 0 add, 1 subtract (a + ~b + cin), 2 and, 3 xor; entry {carry, nibble}
  function automatic logic [BW:0] model_ent(int o, int c, int x, int y);
    case (o)
      0: return 5'(x + y + c);
      1: return 5'(x + ((~y) & 4'hF) + c);
      2: return {1'b0, 4'(x & y)};
      default: return {1'b0, 4'(x ^ y)};
    endcase
  endfunction

  // {op, a, b, cin, result, carry, zero, neg}
  localparam logic [29:0] VEC [10] = '{
    {2'd0, 8'h12, 8'h34, 1'b0, 8'h46, 1'b0, 1'b0, 1'b0},
    {2'd0, 8'hF0, 8'h10, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0},
    {2'd0, 8'h0F, 8'h01, 1'b0, 8'h10, 1'b0, 1'b0, 1'b0},
    {2'd0, 8'h7F, 8'h01, 1'b1, 8'h81, 1'b0, 1'b0, 1'b1},
    {2'd0, 8'hFF, 8'h00, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0},
    {2'd1, 8'h50, 8'h20, 1'b1, 8'h30, 1'b1, 1'b0, 1'b0},
    {2'd1, 8'h20, 8'h50, 1'b1, 8'hD0, 1'b0, 1'b0, 1'b1},
    {2'd2, 8'hF0, 8'h3C, 1'b0, 8'h30, 1'b0, 1'b0, 1'b0},
    {2'd3, 8'hAA, 8'hAA, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0},
    {2'd3, 8'h5A, 8'hFF, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tbl_write(int adr, logic [BW:0] d);
    tbl_we = 1'b1; tbl_addr = AW'(adr); tbl_data = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // launch and wait; checks latency, pulse width, result and flags
  task automatic run_op(string req, logic [1:0] o, logic [7:0] x, logic [7:0] y,
                        logic c, logic [7:0] er, logic ec, logic ez, logic en);
    int lat = 0;
    op = o; a = x; b = y; cin = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!valid && lat < 10) begin @(negedge clk); lat++; end
    chk({req, " latency R3"}, lat, 3);
    chk({req, " result R2"}, result, er);
    chk({req, " flags R5 R6 R7"}, {zero, carry, neg}, {ez, ec, en});
    @(negedge clk);
    chk({req, " pulse R3"}, valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk("R12 reset", {valid, busy, result, zero, carry, neg}, 0);

    // R1 load full table
    for (int o = 0; o < 4; o++)
      for (int c = 0; c < 2; c++)
        for (int x = 0; x < 16; x++)
          for (int y = 0; y < 16; y++)
            tbl_write((o << 9) | (c << 8) | (x << 4) | y, model_ent(o, c, x, y));

    // vector table, R2 carry-select in rows with a low-pass carry
    for (int i = 0; i < 10; i++)
      run_op($sformatf("vec%0d", i), VEC[i][29:28], VEC[i][27:20], VEC[i][19:12],
             VEC[i][11], VEC[i][10:3], VEC[i][2], VEC[i][1], VEC[i][0]);

    // R4 R8 hold between completions
    repeat (4) @(negedge clk);
    chk("R4 R8 hold", {result, zero, carry, neg}, {8'hA5, 1'b0, 1'b0, 1'b1});

    // R1 rewrite an entry; R2 low carry 1 picks high entry with cin 1, R6 carry 0
    tbl_write((3 << 9) | (1 << 8) | (2 << 4) | 3, 5'h1E);
    run_op("R1 rewrite", 2'd3, 8'h02, 8'h03, 1'b1, 8'h0E, 1'b0, 1'b0, 1'b0);

    // R11 start while busy ignored
    op = 0; a = 8'h12; b = 8'h34; cin = 0; start = 1'b1;
    @(negedge clk);
    chk("R3 busy", busy, 1);
    op = 3; a = 8'hFF; b = 8'h00;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R11 first result", {valid, result}, {1'b1, 8'h46});
    begin
      int extra = 0;
      for (int k = 0; k < 5; k++) begin @(negedge clk); if (valid) extra++; end
      chk("R11 no extra valid", extra, 0);
    end
    chk("R11 result kept", result, 8'h46);

    // R9 write while busy dropped
    op = 3; a = 8'h11; b = 8'h11; cin = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tbl_write((3 << 9) | (1 << 4) | 1, 5'h1F);
    @(negedge clk);
    chk("R9 op during write", result, 8'h00);
    @(negedge clk);
    run_op("R9 table intact", 2'd3, 8'h11, 8'h11, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);

    // R10 start with write deferred, operands captured
    op = 0; a = 8'h0F; b = 8'h01; cin = 0; start = 1'b1;
    tbl_we = 1'b1; tbl_addr = AW'(2 << 9); tbl_data = model_ent(2, 0, 0, 0);
    @(negedge clk);
    start = 1'b0; tbl_we = 1'b0; a = 8'h00; b = 8'h00;
    chk("R10 pending busy", busy, 1);
    @(negedge clk);
    @(negedge clk);
    chk("R10 not yet valid", valid, 0);
    @(negedge clk);
    chk("R10 deferred result", {valid, result}, {1'b1, 8'h10});

    // R12 reset clears holding register and flags
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R12 reset again", {valid, busy, result, zero, carry, neg}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule